// File: doc/BRIEF.md
# Memory Scanner Controller

The block walks a region of a single-port memory, one word at a time, from a software-programmed low address up to a high address. Each word is handed to an external CRC engine over a valid/ready handshake. The low address register advances by one after every word the CRC side accepts, so software can watch the scan's progress by reading it. A scan starts when software sets the enable and go bits. It stops when hardware clears go: the range is exhausted, the address leaves the valid memory window, or the CRC engine drops its go signal.

A two-bit access mode decides how the scanner shares the memory port with the CPU:

- **Concurrent:** steals one slot per word.
- **Burst:** holds the CPU off for the whole scan.
- **Peek:** reads only in cycles where the CPU leaves the memory alone.
- **Trigger:** performs one access per rising edge of a trigger input.

An interrupt-management bit chooses between two behaviours. In one, the scan pauses while an interrupt response is active. In the other, interrupt handling is stalled for the scanner.

Top module: `mem_scanner`

## Requirements
- R1: The control word reads back as mode in bits [1:0] (00 concurrent, 01 burst, 10 peek, 11 trigger), interrupt-management in bit 2, go in bit 3, enable in bit 4, busy in bit 5 and abort in bit 6. The writable control bits are [4:0]. After reset, the writable fields and both address registers are 0.
- R2: A scan delivers the image words of addresses low..high in ascending order, one per accepted handshake. The low address register ends one past the last delivered address. While valid is high and ready is low, the word stays stable.
- R3: Once the word at the high address is accepted, hardware clears go and no further memory request is issued.
- R4: Abort reads 1 when the low address lies outside [ADDR_MIN, ADDR_MAX] or the CRC enable input is low. Writing go=1 under abort, or while CRC go is low, leaves go at 0 and starts nothing. A scan that steps past ADDR_MAX stops with go cleared.
- R5: If CRC go falls during a scan, go is cleared. A word that has already been requested still completes its handshake, and no further word follows.
- R6: Busy is 1 from the cycle after an access starts until its word is accepted.
- R7: While enable is 0, no new access starts and go, mode, the low address and the high address keep their values, even if CRC go falls. Setting enable again resumes the scan at the same address.
- R8: With interrupt-management 1 in modes 00, 01 and 11, no access starts while the interrupt-activity input is high, and the interrupt stall output stays 0.
- R9: With interrupt-management 0 in modes 00 and 11, the interrupt stall output equals the memory request output.
- R10: In burst mode, the CPU stall output is high while enable and go are both set, or while busy. With interrupt-management 0 in burst mode, the interrupt stall output equals the go bit.
- R11: In peek mode, the memory request is never high while the CPU-activity input is high. Both stall outputs stay 0 regardless of interrupt-management.
- R12: Trigger mode performs exactly one memory access per rising edge of the trigger input seen while enabled and go. In modes 00 and 11, the CPU stall output equals the memory request output.
- R13: A software write to the low address in the same cycle as an accepted word takes priority over the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 5 | Control write data: {enable, go, int-mgmt, mode[1:0]} |
| lo_we_i | input | 1 | Low address write strobe |
| lo_wdata_i | input | ADDR_W | Low address write data |
| hi_we_i | input | 1 | High address write strobe |
| hi_wdata_i | input | ADDR_W | High address write data |
| ctl_rdata_o | output | 7 | Control word read value (layout in R1) |
| lo_o | output | ADDR_W | Current low address |
| hi_o | output | ADDR_W | Current high address |
| crc_en_i | input | 1 | CRC engine enabled |
| crc_go_i | input | 1 | CRC engine running |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_gnt_i | input | 1 | Memory grant; read data valid in the same cycle |
| mem_rdata_i | input | DATA_W | Memory read data |
| crc_valid_o | output | 1 | Word valid toward the CRC engine |
| crc_data_o | output | DATA_W | Word toward the CRC engine |
| crc_ready_i | input | 1 | CRC engine accepts the word |
| cpu_active_i | input | 1 | CPU is using the memory this cycle |
| irq_active_i | input | 1 | Interrupt response in progress |
| trig_i | input | 1 | Trigger for trigger mode |
| cpu_stall_o | output | 1 | Holds the CPU off the memory |
| irq_stall_o | output | 1 | Holds off interrupt handling |

## Verification
The increment of the low address on an accepted word and a software write to that same register can land on the same clock edge. The bench provokes this by holding the CRC ready low until a word is waiting. It then raises ready and writes a new low address in the same cycle. It judges the outcome by reading back the written value, and by checking that the next delivered word comes from the new address rather than the incremented one.

// File: rtl/mscan_pkg.sv
package mscan_pkg;

  typedef enum logic [1:0] {
    MD_CONC  = 2'b00,
    MD_BURST = 2'b01,
    MD_PEEK  = 2'b10,
    MD_TRIG  = 2'b11
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_READ = 2'b01,
    ST_HAND = 2'b10
  } scan_state_e;

  // control write/read bit positions
  localparam int CB_INTM  = 2;
  localparam int CB_GO    = 3;
  localparam int CB_EN    = 4;
  localparam int CTL_WR_W = 5;
  localparam int CTL_RD_W = 7;

endpackage

// File: rtl/mscan_regs.sv
module mscan_regs
  import mscan_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int ADDR_MIN = 16,
  parameter int ADDR_MAX = 239
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we_i,
  input  logic [CTL_WR_W-1:0] ctl_wdata_i,
  input  logic                lo_we_i,
  input  logic [ADDR_W-1:0]   lo_wdata_i,
  input  logic                hi_we_i,
  input  logic [ADDR_W-1:0]   hi_wdata_i,
  input  logic                crc_en_i,
  input  logic                crc_go_i,
  input  logic                idle_i,
  input  logic                adv_i,
  input  logic [ADDR_W-1:0]   adv_addr_i,
  output logic                en_o,
  output logic                go_o,
  output logic                intm_o,
  output scan_mode_e          mode_o,
  output logic [ADDR_W-1:0]   lo_o,
  output logic [ADDR_W-1:0]   hi_o,
  output logic                lo_valid_o,
  output logic                past_end_o
);

  localparam logic [ADDR_W-1:0] LO_BOUND = ADDR_W'(ADDR_MIN);
  localparam logic [ADDR_W-1:0] HI_BOUND = ADDR_W'(ADDR_MAX);

  logic              en_q, en_d, go_q, go_d, intm_q, intm_d;
  scan_mode_e        mode_q, mode_d;
  logic [ADDR_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              crc_ok, hw_clr;

  assign crc_ok     = crc_en_i & crc_go_i;
  assign lo_valid_o = (lo_q >= LO_BOUND) && (lo_q <= HI_BOUND);
  assign past_end_o = lo_q > hi_q;
  // hardware clears go only while enabled, so a disabled scanner keeps state
  assign hw_clr     = en_q & go_q &
                      (~crc_ok | (idle_i & (past_end_o | ~lo_valid_o)));

  always_comb begin
    en_d   = en_q;
    intm_d = intm_q;
    mode_d = mode_q;
    go_d   = go_q;
    if (ctl_we_i) begin
      en_d   = ctl_wdata_i[CB_EN];
      intm_d = ctl_wdata_i[CB_INTM];
      mode_d = scan_mode_e'(ctl_wdata_i[1:0]);
      go_d   = ctl_wdata_i[CB_GO] & crc_ok & lo_valid_o;
    end else if (hw_clr) begin
      go_d   = 1'b0;
    end
    lo_d = lo_q;
    if (lo_we_i)    lo_d = lo_wdata_i;
    else if (adv_i) lo_d = adv_addr_i + 1'b1;
    hi_d = hi_we_i ? hi_wdata_i : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      go_q   <= 1'b0;
      intm_q <= 1'b0;
      mode_q <= MD_CONC;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      en_q   <= en_d;
      go_q   <= go_d;
      intm_q <= intm_d;
      mode_q <= mode_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  assign en_o   = en_q;
  assign go_o   = go_q;
  assign intm_o = intm_q;
  assign mode_o = mode_q;
  assign lo_o   = lo_q;
  assign hi_o   = hi_q;

  assert_refuse_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we_i && ctl_wdata_i[CB_GO] && !crc_en_i) |=> !go_q);

  assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctl_we_i && !lo_we_i && !hi_we_i && idle_i)
      |=> ($stable(lo_q) && $stable(go_q) && $stable(hi_q)));

endmodule

// File: rtl/mscan_gate.sv
module mscan_gate
  import mscan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  scan_mode_e mode_i,
  input  logic       intm_i,
  input  logic       en_i,
  input  logic       go_i,
  input  logic       irq_active_i,
  input  logic       cpu_active_i,
  input  logic       trig_i,
  input  logic       in_read_i,
  input  logic       busy_i,
  input  logic       start_i,
  output logic       may_start_o,
  output logic       mem_req_o,
  output logic       cpu_stall_o,
  output logic       irq_stall_o
);

  logic trig_q, pend_q, pend_d;
  logic run, is_peek, is_trig, pause, mode_ok;

  assign run     = en_i & go_i;
  assign is_peek = (mode_i == MD_PEEK);
  assign is_trig = (mode_i == MD_TRIG);
  assign pause   = intm_i & ~is_peek & irq_active_i;

  always_comb begin
    // one pending access per trigger edge; consumed when the access starts
    pend_d  = is_trig & run & ((trig_i & ~trig_q) | (pend_q & ~start_i));
    mode_ok = is_trig ? pend_q : 1'b1;
    may_start_o = mode_ok & ~pause;
    mem_req_o   = in_read_i & ~(is_peek & cpu_active_i);
    unique case (mode_i)
      MD_BURST: cpu_stall_o = run | busy_i;
      MD_PEEK:  cpu_stall_o = 1'b0;
      default:  cpu_stall_o = in_read_i;
    endcase
    if (intm_i || is_peek)       irq_stall_o = 1'b0;
    else if (mode_i == MD_BURST) irq_stall_o = go_i;
    else                         irq_stall_o = in_read_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      trig_q <= trig_i;
      pend_q <= pend_d;
    end
  end

  assert_irq_pause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (intm_i && !is_peek && irq_active_i && !busy_i) |=> !busy_i);

  assert_trig_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (is_trig && !busy_i && !pend_q) |=> !busy_i);

endmodule

// File: rtl/mscan_fsm.sv
module mscan_fsm
  import mscan_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic              mem_fire_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              crc_ready_i,
  output logic              idle_o,
  output logic              in_read_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              crc_valid_o,
  output logic [DATA_W-1:0] crc_data_o,
  output logic              adv_o
);

  scan_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              cap_addr, cap_data;

  always_comb begin
    state_d  = state_q;
    cap_addr = 1'b0;
    cap_data = 1'b0;
    adv_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_READ;
        cap_addr = 1'b1;
      end
      ST_READ: if (mem_fire_i) begin
        state_d  = ST_HAND;
        cap_data = 1'b1;
      end
      ST_HAND: if (crc_ready_i) begin
        state_d = ST_IDLE;
        adv_o   = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cap_addr) addr_q <= lo_i;
      if (cap_data) data_q <= mem_rdata_i;
    end
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign in_read_o   = (state_q == ST_READ);
  assign busy_o      = ~idle_o;
  assign crc_valid_o = (state_q == ST_HAND);
  assign crc_data_o  = data_q;
  assign addr_o      = addr_q;

  assert_word_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_valid_o && !crc_ready_i) |=> (crc_valid_o && $stable(crc_data_o)));

  assert_grant_to_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read_o && mem_fire_i) |=> (crc_valid_o && busy_o));

endmodule

// File: rtl/mem_scanner.sv
module mem_scanner
  import mscan_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int ADDR_MIN = 16,
  parameter int ADDR_MAX = 239
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we_i,
  input  logic [CTL_WR_W-1:0] ctl_wdata_i,
  input  logic                lo_we_i,
  input  logic [ADDR_W-1:0]   lo_wdata_i,
  input  logic                hi_we_i,
  input  logic [ADDR_W-1:0]   hi_wdata_i,
  output logic [CTL_RD_W-1:0] ctl_rdata_o,
  output logic [ADDR_W-1:0]   lo_o,
  output logic [ADDR_W-1:0]   hi_o,
  input  logic                crc_en_i,
  input  logic                crc_go_i,
  output logic                mem_req_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic                mem_gnt_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                crc_valid_o,
  output logic [DATA_W-1:0]   crc_data_o,
  input  logic                crc_ready_i,
  input  logic                cpu_active_i,
  input  logic                irq_active_i,
  input  logic                trig_i,
  output logic                cpu_stall_o,
  output logic                irq_stall_o
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic       en, go, intm, lo_valid, past_end;
  scan_mode_e mode;
  logic       idle, in_read, busy, adv, may_start, start, mem_fire;

  assign start    = idle & en & go & crc_en_i & crc_go_i & lo_valid & ~past_end & may_start;
  assign mem_fire = mem_req_o & mem_gnt_i;

  mscan_regs #(.ADDR_W(ADDR_W), .ADDR_MIN(ADDR_MIN), .ADDR_MAX(ADDR_MAX)) u_regs (
    .clk        (clk),
    .rst_n      (rst_ni),
    .ctl_we_i   (ctl_we_i),
    .ctl_wdata_i(ctl_wdata_i),
    .lo_we_i    (lo_we_i),
    .lo_wdata_i (lo_wdata_i),
    .hi_we_i    (hi_we_i),
    .hi_wdata_i (hi_wdata_i),
    .crc_en_i   (crc_en_i),
    .crc_go_i   (crc_go_i),
    .idle_i     (idle),
    .adv_i      (adv),
    .adv_addr_i (mem_addr_o),
    .en_o       (en),
    .go_o       (go),
    .intm_o     (intm),
    .mode_o     (mode),
    .lo_o       (lo_o),
    .hi_o       (hi_o),
    .lo_valid_o (lo_valid),
    .past_end_o (past_end)
  );

  mscan_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_ni),
    .mode_i      (mode),
    .intm_i      (intm),
    .en_i        (en),
    .go_i        (go),
    .irq_active_i(irq_active_i),
    .cpu_active_i(cpu_active_i),
    .trig_i      (trig_i),
    .in_read_i   (in_read),
    .busy_i      (busy),
    .start_i     (start),
    .may_start_o (may_start),
    .mem_req_o   (mem_req_o),
    .cpu_stall_o (cpu_stall_o),
    .irq_stall_o (irq_stall_o)
  );

  mscan_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_ni),
    .start_i    (start),
    .lo_i       (lo_o),
    .mem_fire_i (mem_fire),
    .mem_rdata_i(mem_rdata_i),
    .crc_ready_i(crc_ready_i),
    .idle_o     (idle),
    .in_read_o  (in_read),
    .busy_o     (busy),
    .addr_o     (mem_addr_o),
    .crc_valid_o(crc_valid_o),
    .crc_data_o (crc_data_o),
    .adv_o      (adv)
  );

  assign ctl_rdata_o = {~lo_valid | ~crc_en_i, busy, en, go, intm, mode};

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (crc_valid_o && crc_ready_i && !lo_we_i) |=> (lo_o == $past(mem_addr_o) + 1'b1));

  assert_quiet_when_done_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!go && !busy) |-> !mem_req_o);

  assert_crc_drop_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && go && !crc_go_i) |=> !go);

  assert_peek_yield_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == MD_PEEK) |-> !(mem_req_o && cpu_active_i));

endmodule

// File: tb/mem_scanner_tb.sv
`timescale 1ns/1ps
module mem_scanner_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic       lo_we = 1'b0, hi_we = 1'b0;
  logic [7:0] lo_wdata = '0, hi_wdata = '0;
  logic [6:0] ctl_rdata;
  logic [7:0] lo_q, hi_q, mem_addr;
  logic       crc_en = 1'b0, crc_go = 1'b0;
  logic       mem_req, gnt = 1'b0, crc_valid, ready = 1'b0;
  logic [15:0] mem_rdata, crc_data;
  logic       cpu_act = 1'b0, irq_act = 1'b0, trig = 1'b0;
  logic       cpu_stall, irq_stall;

  bit   rnd_en = 1'b0, irq_rnd = 1'b0, mon_on = 1'b0, prev_hold = 1'b0;
  int   n_chk = 0, n_bad = 0, words = 0;
  logic [7:0] exp_addr = '0;

  always #2 clk = ~clk;

  function automatic logic [15:0] img(input logic [7:0] a);
    return {a ^ 8'h5C, a * 8'd7 + 8'd3};
  endfunction

  assign mem_rdata = img(mem_addr);

  mem_scanner u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .lo_we_i(lo_we), .lo_wdata_i(lo_wdata), .hi_we_i(hi_we), .hi_wdata_i(hi_wdata),
    .ctl_rdata_o(ctl_rdata), .lo_o(lo_q), .hi_o(hi_q), .crc_en_i(crc_en), .crc_go_i(crc_go),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(gnt), .mem_rdata_i(mem_rdata),
    .crc_valid_o(crc_valid), .crc_data_o(crc_data), .crc_ready_i(ready),
    .cpu_active_i(cpu_act), .irq_active_i(irq_act), .trig_i(trig),
    .cpu_stall_o(cpu_stall), .irq_stall_o(irq_stall));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // random environment, driven just after each rising edge
  always @(posedge clk) begin
    #1;
    if (rnd_en) begin
      gnt     = ($urandom % 4) != 0;
      ready   = ($urandom % 4) != 0;
      cpu_act = ($urandom % 3) == 0;
      irq_act = irq_rnd && (($urandom % 5) == 0);
    end
  end

  // stream scoreboard and per-mode stall monitors, sampled mid-cycle
  always @(negedge clk) begin
    if (mon_on) begin
      if (crc_valid && ready) begin
        chk(crc_data == img(exp_addr), "R2 word", crc_data, img(exp_addr));
        exp_addr = exp_addr + 8'd1;
        words++;
      end
      case (ctl_rdata[1:0])
        2'b10: begin
          if (mem_req) chk(!cpu_act, "R11 peek request", cpu_act, 0);
          chk(!cpu_stall && !irq_stall, "R11 peek stalls", {cpu_stall, irq_stall}, 0);
        end
        2'b01: begin
          chk(cpu_stall == ((ctl_rdata[4] & ctl_rdata[3]) | ctl_rdata[5]), "R10 burst cpu stall",
              cpu_stall, (ctl_rdata[4] & ctl_rdata[3]) | ctl_rdata[5]);
          if (!ctl_rdata[2]) chk(irq_stall == ctl_rdata[3], "R10 burst irq stall", irq_stall, ctl_rdata[3]);
        end
        default: begin
          chk(cpu_stall == mem_req, "R12 cpu stall per slot", cpu_stall, mem_req);
          if (!ctl_rdata[2]) chk(irq_stall == mem_req, "R9 irq stall per access", irq_stall, mem_req);
        end
      endcase
      if (ctl_rdata[2] && ctl_rdata[1:0] != 2'b10) begin
        chk(!irq_stall, "R8 irq stall low", irq_stall, 0);
        if (prev_hold) chk(!ctl_rdata[5], "R8 paused by interrupt", ctl_rdata[5], 0);
      end
      prev_hold = ctl_rdata[2] && ctl_rdata[1:0] != 2'b10 && irq_act && !ctl_rdata[5];
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_ctl(input bit en, input bit go, input bit im, input logic [1:0] md);
    ctl_we = 1'b1; ctl_wdata = {en, go, im, md};
    tick(1);
    ctl_we = 1'b0;
  endtask

  task automatic wr_range(input logic [7:0] lo, input logic [7:0] hi);
    lo_we = 1'b1; lo_wdata = lo; hi_we = 1'b1; hi_wdata = hi;
    tick(1);
    lo_we = 1'b0; hi_we = 1'b0;
  endtask

  task automatic wait_done();
    for (int c = 0; c < 4000; c++) begin
      if (!ctl_rdata[3] && !ctl_rdata[5]) break;
      trig = (ctl_rdata[1:0] == 2'b11) && (c % 10 == 3);
      tick(1);
    end
    trig = 1'b0;
  endtask

  task automatic run_scan(input logic [1:0] md, input bit im, input logic [7:0] lo,
                          input logic [7:0] hi, input int exp_n);
    wr_range(lo, hi);
    exp_addr = lo; words = 0;
    wr_ctl(1'b1, 1'b1, im, md);
    wait_done();
    tick(6);
    chk(words == exp_n, "R2 word count", words, exp_n);
    chk(lo_q == lo + 8'(exp_n), "R2 final low address", lo_q, lo + 8'(exp_n));
    chk(!ctl_rdata[3], "R3 go cleared at end", ctl_rdata[3], 0);
    chk(!ctl_rdata[5] && !mem_req, "R3 no request after end", {ctl_rdata[5], mem_req}, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset values: only abort set while the CRC is disabled
    chk(ctl_rdata == 7'h40, "R1 reset control", ctl_rdata, 7'h40);
    chk(lo_q == 0 && hi_q == 0, "R1 reset addresses", {lo_q, hi_q}, 0);
    mon_on = 1'b1;

    // R1 field layout
    wr_ctl(1'b0, 1'b0, 1'b1, 2'b10);
    chk(ctl_rdata[4:0] == 5'b00110, "R1 field layout", ctl_rdata[4:0], 5'b00110);

    // R4 go refused while CRC disabled
    wr_range(8'h20, 8'h24);
    wr_ctl(1'b1, 1'b1, 1'b0, 2'b00);
    tick(3);
    chk(ctl_rdata[6] && !ctl_rdata[3] && !ctl_rdata[5], "R4 refuse without CRC", ctl_rdata, 7'h50);
    crc_en = 1'b1; crc_go = 1'b1;
    tick(1);
    chk(!ctl_rdata[6], "R4 abort clear", ctl_rdata[6], 0);

    // R4 invalid low address
    words = 0;
    wr_range(8'h05, 8'h30);
    chk(ctl_rdata[6], "R4 abort on invalid low", ctl_rdata[6], 1);
    wr_ctl(1'b1, 1'b1, 1'b0, 2'b00);
    tick(8);
    chk(!ctl_rdata[3] && words == 0, "R4 go refused on invalid low", {ctl_rdata[3], words[7:0]}, 0);

    // R3 empty range: low above high
    wr_range(8'h50, 8'h4F);
    wr_ctl(1'b1, 1'b1, 1'b0, 2'b00);
    tick(3);
    chk(!ctl_rdata[3] && words == 0, "R3 empty range", {ctl_rdata[3], words[7:0]}, 0);

    // all modes, both interrupt policies, random traffic
    rnd_en = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int im = 0; im < 2; im++) begin
        logic [7:0] lo;
        int n;
        irq_rnd = 1'b1;
        lo = 8'h10 + 8'($urandom % 160);
        n  = 1 + int'($urandom % 20);
        run_scan(2'(m), im[0], lo, lo + 8'(n - 1), n);
      end
    end
    irq_rnd = 1'b0;

    // R4 scan running past the top of the valid window
    run_scan(2'b00, 1'b0, 8'hEC, 8'hFF, 4);
    chk(ctl_rdata[6], "R4 abort past window", ctl_rdata[6], 1);

    // R12 exactly one access per trigger edge
    wr_range(8'h20, 8'h2F);
    exp_addr = 8'h20; words = 0;
    wr_ctl(1'b1, 1'b1, 1'b0, 2'b11);
    tick(10);
    chk(words == 0, "R12 no access without edge", words, 0);
    for (int k = 1; k <= 4; k++) begin
      trig = 1'b1; tick(1); trig = 1'b0;
      for (int c = 0; c < 300 && words < k; c++) tick(1);
      tick(10);
      chk(words == k, "R12 one word per edge", words, k);
    end
    chk(lo_q == 8'h24, "R12 low after four edges", lo_q, 8'h24);
    wr_ctl(1'b1, 1'b0, 1'b0, 2'b11);

    // R7 disable mid-scan, state kept, resume
    wr_range(8'h40, 8'h7F);
    exp_addr = 8'h40; words = 0;
    wr_ctl(1'b1, 1'b1, 1'b0, 2'b00);
    for (int c = 0; c < 500 && words < 5; c++) tick(1);
    wr_ctl(1'b0, 1'b1, 1'b0, 2'b00);
    for (int c = 0; c < 50 && ctl_rdata[5]; c++) tick(1);
    begin
      logic [7:0] lo_snap;
      int w_snap;
      lo_snap = lo_q; w_snap = words;
      crc_go = 1'b0; tick(5); crc_go = 1'b1;
      tick(20);
      chk(words == w_snap, "R7 no access while disabled", words, w_snap);
      chk(lo_q == lo_snap && hi_q == 8'h7F, "R7 addresses kept", {lo_q, hi_q}, {lo_snap, 8'h7F});
      chk(ctl_rdata[3] && ctl_rdata[1:0] == 2'b00, "R7 go and mode kept", ctl_rdata, 7'h08);
    end
    wr_ctl(1'b1, 1'b1, 1'b0, 2'b00);
    wait_done();
    tick(4);
    chk(words == 64 && lo_q == 8'h80, "R7 resumed to end", {words[7:0], lo_q}, {8'd64, 8'h80});

    // R5 CRC go drops with a word waiting; R6 busy through handshake
    rnd_en = 1'b0; tick(2);
    gnt = 1'b1; ready = 1'b0; cpu_act = 1'b0; irq_act = 1'b0;
    wr_range(8'h80, 8'h9F);
    exp_addr = 8'h80; words = 0;
    wr_ctl(1'b1, 1'b1, 1'b0, 2'b00);
    for (int c = 0; c < 20 && !crc_valid; c++) tick(1);
    chk(ctl_rdata[5], "R6 busy while word waits", ctl_rdata[5], 1);
    crc_go = 1'b0; tick(1); crc_go = 1'b1;
    chk(!ctl_rdata[3] && crc_valid, "R5 go cleared, word held", {ctl_rdata[3], crc_valid}, 2'b01);
    ready = 1'b1; tick(10);
    chk(words == 1 && !ctl_rdata[5], "R5 in-flight word only", words, 1);

    // R13 low-address write collides with an accepted word
    ready = 1'b0;
    wr_range(8'h30, 8'h3F);
    exp_addr = 8'h30; words = 0;
    wr_ctl(1'b1, 1'b1, 1'b0, 2'b00);
    for (int c = 0; c < 20 && !crc_valid; c++) tick(1);
    lo_we = 1'b1; lo_wdata = 8'h38; ready = 1'b1;
    tick(1);
    lo_we = 1'b0;
    chk(lo_q == 8'h38, "R13 software write wins", lo_q, 8'h38);
    exp_addr = 8'h38;
    wait_done();
    tick(4);
    chk(words == 9, "R13 scan continues from written address", words, 9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule